// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a chain of command packets stored in system memory and streams each packet's payload words to a downstream command consumer. Every packet begins with a header word. The header carries the payload length and the address of the next packet. The walker fetches one header, fetches and forwards the payload words that follow it, and then moves to the next packet. It stops when it reaches an end marker, when it finds a loop in the chain, or, in incremental mode, when its cycle budget is spent.

While it walks, the block keeps an estimate of the bus cycles the chain would cost. It also keeps a loop checkpoint: an address that the next pointer of every packet is compared against. The checkpoint is refreshed at node counts that double each time, so a cycle of any length is caught. When the walk ends, the block raises a one-cycle done pulse. At that moment it presents the address it reached, the cycle total and a loop flag. In incremental mode the reported address is where the walk paused, and a new start from that address continues the chain.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset, `out_valid_o`, `done_o`, `busy_o` and `mem_req_o` are low.
- R2: A header word holds the payload length in bits 31:24 and the next-packet address in bits 23:0. The payload words sit at the word addresses directly after the header and leave on `out_data_o` in ascending address order. Each word appears exactly once.
- R3: Each memory read uses bits 20:2 of the address, with bits 1:0 driven to zero. Payload addresses wrap inside this 2 MB window. Only one read is outstanding at any time.
- R4: The walk stops as soon as bit 23 of the current address is set. A start address with bit 23 set finishes without any memory read, with a cycle total of 0, and reports the start address.
- R5: Each visited packet adds 10 to the cycle total. A packet with a nonzero payload length L adds a further 5 + L. The total is cleared at each start.
- R6: The loop checkpoint is loaded with the start address. If a packet's next address equals the checkpoint, the walk stops with `loop_o` = 1 and reports that next address.
- R7: The threshold starts at 32. Packets are counted from 0. When the index of the packet being finished equals the threshold, the checkpoint takes that packet's next address and the threshold doubles.
- R8: With `incr_i` = 1 at start, the walk pauses after any packet that leaves the cycle total above 512. It then reports that packet's next address with `loop_o` = 0. This test comes before the loop comparison.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` does not change.
- R10: `done_o` is a single-cycle pulse. `final_addr_o`, `cycles_o` and `loop_o` are valid with it and hold until the next start.
- R11: A `start_i` pulse while the walker is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only when idle |
| start_addr_i | input | 24 | Address of the first packet |
| incr_i | input | 1 | Incremental mode: pause once the budget is spent |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | 21 | Word-aligned byte address of the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| out_valid_o | output | 1 | Payload word valid |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_data_o | output | 32 | Payload word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished (one cycle) |
| final_addr_o | output | 24 | Address where the walk ended or paused |
| cycles_o | output | 32 | Accumulated cycle estimate |
| loop_o | output | 1 | The walk ended on a detected loop |

## Verification
The bench targets loops that do not pass through the start address, which are caught only after the checkpoint has been refreshed at packet 32. A design with a wrong threshold index or a missed doubling would hang, or would report the loop at a different packet and a different cycle total. It also targets addresses above the 2 MB window and payloads that wrap past its top. Here a design that skips the address reduction, or masks the address too early, would read the wrong words or would fail to match the checkpoint. Incremental runs are split and resumed from the reported address, and stray starts and a stalling consumer are applied in the middle of a walk. Errors in the budget test, the restart guard or the output hold therefore show up as lost, repeated or reordered payload words, or as wrong totals.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_PAY_REQ,
    ST_PAY_WAIT,
    ST_PAY_OUT,
    ST_NODE_END,
    ST_DONE
  } walk_state_e;

endpackage

// File: rtl/dma_chain_cost.sv
module dma_chain_cost #(
  parameter int CYC_W     = 32,
  parameter int LEN_W     = 8,
  parameter int NODE_COST = 10,
  parameter int PAY_COST  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CYC_W-1:0] total_o
);

  logic [CYC_W-1:0] acc_q;
  logic [CYC_W-1:0] inc;

  always_comb begin
    inc = CYC_W'(NODE_COST);
    if (len_i != '0) inc = inc + CYC_W'(PAY_COST) + CYC_W'(len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (add_i)   acc_q <= acc_q + inc;
  end

  assign total_o = acc_q;

endmodule

// File: rtl/dma_chain_loopdet.sv
module dma_chain_loopdet #(
  parameter int ADDR_W   = 24,
  parameter int NODE_W   = 32,
  parameter int THR_INIT = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] init_addr_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  output logic              hit_o
);

  logic [ADDR_W-1:0] chk_q;
  logic [NODE_W-1:0] thr_q;
  logic [NODE_W-1:0] cnt_q;

  assign hit_o = (next_addr_i == chk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= '0;
      thr_q <= NODE_W'(THR_INIT);
      cnt_q <= '0;
    end else if (init_i) begin
      chk_q <= init_addr_i;
      thr_q <= NODE_W'(THR_INIT);
      cnt_q <= '0;
    end else if (step_i) begin
      if (cnt_q == thr_q) begin
        chk_q <= next_addr_i;
        thr_q <= thr_q << 1;
      end
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/dma_chain_emit.sv
module dma_chain_emit #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              taken_o
);

  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign taken_o = vld_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      dat_q <= data_i;
    end else if (taken_o) begin
      vld_q <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;

endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker #(
  parameter int ADDR_W      = 24,
  parameter int WIN_W       = 21,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 8,
  parameter int CYC_W       = 32,
  parameter int NODE_W      = 32,
  parameter int THR_INIT    = 32,
  parameter int NODE_COST   = 10,
  parameter int PAY_COST    = 5,
  parameter int PAUSE_LIMIT = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              incr_i,
  output logic              mem_req_o,
  output logic [WIN_W-1:0]  mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] final_addr_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic              loop_o
);

  import dma_chain_pkg::*;

  localparam int END_BIT = ADDR_W - 1;
  localparam int WORD_B  = DATA_W / 8;

  walk_state_e       state_q;
  logic [ADDR_W-1:0] cur_q, next_q, final_q;
  logic [LEN_W-1:0]  left_q;
  logic [WIN_W-1:0]  ptr_q;
  logic              incr_q, loop_q;

  logic [LEN_W-1:0]  hdr_len;
  logic [ADDR_W-1:0] hdr_next;
  logic [WIN_W-1:0]  cur_base;
  logic              launch, cost_add, ld_init, ld_step, ld_hit;
  logic              emit_load, emit_taken, over_budget;

  assign hdr_len  = mem_rdata_i[DATA_W-1 -: LEN_W];
  assign hdr_next = mem_rdata_i[ADDR_W-1:0];
  assign cur_base = {cur_q[WIN_W-1:2], 2'b00};

  assign launch    = (state_q == ST_IDLE) && start_i;
  assign cost_add  = (state_q == ST_HDR_WAIT) && mem_rvalid_i;
  assign emit_load = (state_q == ST_PAY_WAIT) && mem_rvalid_i;
  assign ld_init   = launch;
  assign over_budget = incr_q && (cycles_o > CYC_W'(PAUSE_LIMIT));
  assign ld_step   = (state_q == ST_NODE_END) && !over_budget && !ld_hit;

  dma_chain_cost #(
    .CYC_W(CYC_W), .LEN_W(LEN_W), .NODE_COST(NODE_COST), .PAY_COST(PAY_COST)
  ) i_cost (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(launch), .add_i(cost_add),
    .len_i(hdr_len), .total_o(cycles_o)
  );

  dma_chain_loopdet #(
    .ADDR_W(ADDR_W), .NODE_W(NODE_W), .THR_INIT(THR_INIT)
  ) i_loopdet (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(ld_init), .init_addr_i(start_addr_i),
    .step_i(ld_step), .next_addr_i(next_q), .hit_o(ld_hit)
  );

  dma_chain_emit #(.DATA_W(DATA_W)) i_emit (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(emit_load), .data_i(mem_rdata_i),
    .ready_i(out_ready_i), .valid_o(out_valid_o), .data_o(out_data_o),
    .taken_o(emit_taken)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      next_q  <= '0;
      final_q <= '0;
      left_q  <= '0;
      ptr_q   <= '0;
      incr_q  <= 1'b0;
      loop_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cur_q  <= start_addr_i;
          incr_q <= incr_i;
          loop_q <= 1'b0;
          if (start_addr_i[END_BIT]) begin
            final_q <= start_addr_i;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_HDR_REQ;
          end
        end
        ST_HDR_REQ: state_q <= ST_HDR_WAIT;
        ST_HDR_WAIT: if (mem_rvalid_i) begin
          next_q  <= hdr_next;
          left_q  <= hdr_len;
          ptr_q   <= cur_base + WIN_W'(WORD_B);
          state_q <= (hdr_len != '0) ? ST_PAY_REQ : ST_NODE_END;
        end
        ST_PAY_REQ: state_q <= ST_PAY_WAIT;
        ST_PAY_WAIT: if (mem_rvalid_i) begin
          left_q  <= left_q - 1'b1;
          ptr_q   <= ptr_q + WIN_W'(WORD_B);
          state_q <= ST_PAY_OUT;
        end
        ST_PAY_OUT: if (emit_taken) begin
          state_q <= (left_q == '0) ? ST_NODE_END : ST_PAY_REQ;
        end
        ST_NODE_END: begin
          if (over_budget) begin
            final_q <= next_q;
            state_q <= ST_DONE;
          end else if (ld_hit) begin
            final_q <= next_q;
            loop_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            cur_q <= next_q;
            if (next_q[END_BIT]) begin
              final_q <= next_q;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_HDR_REQ;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = (state_q == ST_HDR_REQ) || (state_q == ST_PAY_REQ);
    mem_addr_o = (state_q == ST_HDR_REQ) ? cur_base : ptr_q;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign final_addr_o = final_q;
  assign loop_o       = loop_q;

endmodule

// File: rtl/dma_chain_walker_chk.sv
module dma_chain_walker_chk #(
  parameter int ADDR_W      = 24,
  parameter int WIN_W       = 21,
  parameter int DATA_W      = 32,
  parameter int CYC_W       = 32,
  parameter int PAUSE_LIMIT = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic [WIN_W-1:0]  mem_addr_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] final_addr_o,
  input logic [CYC_W-1:0]  cycles_o,
  input logic              loop_o
);

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  // R3
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R4
  stop_reason_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> final_addr_o[ADDR_W-1] || loop_o || (cycles_o > CYC_W'(PAUSE_LIMIT)));

  // R6
  loop_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && loop_o |-> !final_addr_o[ADDR_W-1]);

  // R2
  out_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o || mem_req_o) |-> busy_o);

endmodule

bind dma_chain_walker dma_chain_walker_chk #(
  .ADDR_W(ADDR_W), .WIN_W(WIN_W), .DATA_W(DATA_W), .CYC_W(CYC_W),
  .PAUSE_LIMIT(PAUSE_LIMIT)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .busy_o(busy_o), .done_o(done_o), .final_addr_o(final_addr_o),
  .cycles_o(cycles_o), .loop_o(loop_o)
);

// File: tb/test_dma_chain_walker.sv
module test_dma_chain_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        incr = 1'b0;
  logic        mem_req;
  logic [20:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        busy, done;
  logic [23:0] final_addr;
  logic [31:0] cycles;
  logic        loop_f;

  int n_tests = 0;
  int n_fail  = 0;
  int n_reads = 0;

  logic [31:0] mem [int];
  logic [31:0] exp_q [$];
  logic [23:0] exp_final;
  logic [31:0] exp_cyc;
  logic        exp_loop;
  bit          bp_en = 1'b0;
  logic [7:0]  lfsr = 8'hA5;

  always #2 clk = ~clk;

  dma_chain_walker i_dma_chain_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .incr_i(incr), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .busy_o(busy), .done_o(done),
    .final_addr_o(final_addr), .cycles_o(cycles), .loop_o(loop_f)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    if (mem_req) begin
      n_reads++;
      mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 32'h0;
    end
  end

  // consumer ready pattern, changed just after each edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data  = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) check(out_valid && out_data == prev_data, "R9 hold", out_data, prev_data);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R2 extra word", out_data, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(out_data == e, "R2 payload", out_data, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  function automatic logic [31:0] rd(input logic [23:0] a);
    int k;
    k = int'({a[20:2], 2'b00});
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  task automatic put_node(input logic [23:0] a, input int len, input logic [23:0] nxt,
                          input logic [31:0] base);
    logic [20:0] p;
    p = {a[20:2], 2'b00};
    mem[int'(p)] = {8'(len), nxt};
    for (int i = 0; i < len; i++) begin
      p = p + 21'd4;
      mem[int'(p)] = base + 32'(i);
    end
  endtask

  // reference walk derived from R2..R8
  task automatic ref_walk(input logic [23:0] s, input bit inc);
    logic [23:0] a, chk, nxt;
    logic [31:0] hdr;
    int thr, cnt, len;
    a = s; chk = s; thr = 32; cnt = 0;
    exp_cyc = 0; exp_loop = 0;
    while (!a[23]) begin
      hdr = rd(a); len = int'(hdr[31:24]); nxt = hdr[23:0];
      exp_cyc += 10;
      if (len != 0) exp_cyc += 32'(5 + len);
      for (int i = 1; i <= len; i++) begin
        logic [20:0] p;
        p = {a[20:2], 2'b00} + 21'(4 * i);
        exp_q.push_back(rd({3'b000, p}));
      end
      if (inc && exp_cyc > 512) begin a = nxt; break; end
      if (nxt == chk) begin exp_loop = 1; a = nxt; break; end
      if (cnt == thr) begin chk = nxt; thr = thr * 2; end
      cnt++;
      a = nxt;
    end
    exp_final = a;
  endtask

  task automatic run(input logic [23:0] s, input bit inc, input string tag,
                     input int stray_at);
    int t;
    exp_q.delete();
    ref_walk(s, inc);
    @(negedge clk);
    start = 1'b1; start_addr = s; incr = inc;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 20000) begin
      if (t == stray_at) begin
        // R11: stray start while busy must be ignored
        start = 1'b1; start_addr = 24'h000040; incr = ~inc;
        @(negedge clk);
        start = 1'b0; incr = inc;
      end else @(negedge clk);
      t++;
    end
    check(done, {tag, " R10 done seen"}, 32'(done), 32'h1);
    check(final_addr == exp_final, {tag, " final addr"}, 32'(final_addr), 32'(exp_final));
    check(cycles == exp_cyc, {tag, " R5 cycles"}, cycles, exp_cyc);
    check(loop_f == exp_loop, {tag, " loop flag"}, 32'(loop_f), 32'(exp_loop));
    @(negedge clk);
    check(!done, {tag, " R10 single pulse"}, 32'(done), 32'h0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {tag, " R2 all words"}, 32'(exp_q.size()), 32'h0);
    check(final_addr == exp_final && cycles == exp_cyc, {tag, " R10 status held"},
          cycles, exp_cyc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!out_valid && !done && !busy && !mem_req, "R1 reset", 32'h0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: end marker on start, no reads
    n_reads = 0;
    run(24'h800040, 1'b0, "R4 start-end", -1);
    check(n_reads == 0 && cycles == 0, "R4 no reads", 32'(n_reads), 32'h0);

    // R2/R5: three packets, lengths 2, 0, 3
    put_node(24'h000100, 2, 24'h000200, 32'hA000_0000);
    put_node(24'h000200, 0, 24'h000300, 32'h0);
    put_node(24'h000300, 3, 24'hFFFFFF, 32'hB000_0000);
    run(24'h000100, 1'b0, "R2 chain", -1);
    check(cycles == 45, "R5 cost 45", cycles, 32'd45);

    // R9/R11: same chain with back-pressure and a stray start
    bp_en = 1'b1;
    run(24'h000100, 1'b0, "R11 stray", 6);
    bp_en = 1'b0;

    // R3: address above window, payload wraps at top of window
    put_node(24'h000500, 1, 24'h1FFFF8, 32'hC000_0000);
    put_node(24'h1FFFF8, 2, 24'h800000, 32'hD000_0000);
    run(24'h600500, 1'b0, "R3 window", -1);
    check(cycles == 16 + 17, "R3 cost", cycles, 32'd33);

    // R6: loop through the start address
    put_node(24'h002000, 0, 24'h002100, 32'h0);
    put_node(24'h002100, 0, 24'h002000, 32'h0);
    run(24'h002000, 1'b0, "R6 loop", -1);
    check(loop_f && final_addr == 24'h002000 && cycles == 20, "R6 loop at 2 pkts",
          cycles, 32'd20);

    // R7: loop not through start, caught after checkpoint refresh
    put_node(24'h003000, 0, 24'h003100, 32'h0);
    put_node(24'h003100, 0, 24'h003200, 32'h0);
    put_node(24'h003200, 0, 24'h003100, 32'h0);
    run(24'h003000, 1'b0, "R7 refresh", -1);
    check(loop_f && cycles == 350 && final_addr == 24'h003100, "R7 35 packets",
          cycles, 32'd350);

    // R8: incremental pause and resume
    for (int i = 0; i < 20; i++)
      put_node(24'(32'h10000 + i * 32'h100), 20,
               (i == 19) ? 24'h800000 : 24'(32'h10000 + (i + 1) * 32'h100),
               32'(i) << 16);
    run(24'h010000, 1'b1, "R8 pause", -1);
    check(!loop_f && final_addr == 24'h010F00 && cycles == 525, "R8 pause point",
          cycles, 32'd525);
    run(24'h010F00, 1'b1, "R8 resume", -1);
    check(final_addr == 24'h800000 && cycles == 175, "R8 resume end", cycles, 32'd175);
    run(24'h010000, 1'b0, "R8 off", -1);
    check(cycles == 700, "R8 no pause", cycles, 32'd700);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule